// File: doc/BRIEF.md
# Software Interrupt Request Decoder

This block sits on the write path of an interrupt distributor. It watches for full-word writes to the software interrupt trigger word. From each such write it works out which processors the request goes to. The written word carries three things: an interrupt number, a two-bit target filter and an explicit processor list. The filter has four meanings:

- take the explicit list;
- every processor except the one that wrote the word;
- only the writer;
- every processor (used when the filter code is out of range).

The index of the writing processor arrives on its own input, next to the write.

One cycle after an accepted write, the block raises a single-cycle strobe. With it come the decoded interrupt number and the target mask, so the arbitration logic downstream knows it has to look again. The block also keeps a pending array for the 16 software interrupt numbers on every processor. Each targeted processor gets the pending bit for the written number set. Each processor clears its own bits with an acknowledge strobe that carries the interrupt number. A number of 16 or above is still reported on the strobe outputs, but it leaves the pending array alone.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, `sgi_fire` is low and every bit of `sgi_pending` is zero.
- R2: A write is decoded only when `wr_en` is high, `wr_addr` equals the trigger offset 0xF00, and `wr_word` is high. Any other write produces no strobe and changes no pending bit.
- R3: In the cycle after a decoded write, `sgi_fire` is high for exactly one cycle and `sgi_id` equals bits 9:0 of the written word.
- R4: With filter bits 25:24 equal to 0, `sgi_targets` equals bits 23:16 of the word ANDed with the mask of implemented processors (low NUM_CPU bits set).
- R5: With filter value 1, `sgi_targets` holds every implemented processor except the one given on `wr_cpu`.
- R6: With filter value 2, `sgi_targets` holds only the processor given on `wr_cpu`.
- R7: With filter value 3, `sgi_targets` holds every implemented processor.
- R8: When the interrupt number is below 16, the bit `sgi_pending[c*16+id]` becomes set, in the same cycle as the strobe, for every processor c in the target mask. Other bits keep their value.
- R9: An interrupt number of 16 or above still raises the strobe with its number and mask, but leaves `sgi_pending` unchanged.
- R10: A high `ack_valid[c]` clears `sgi_pending[c*16+ack_id[c*4+:4]]` at the next edge. No other bit changes.
- R11: If a set and an acknowledge hit the same processor and number in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request valid |
| wr_addr | input | 12 | Byte offset of the write within the distributor |
| wr_word | input | 1 | High when the write is a full 32-bit access |
| wr_data | input | 32 | Written word |
| wr_cpu | input | CPU_W | Index of the writing processor |
| ack_valid | input | NUM_CPU | Per-processor acknowledge strobe |
| ack_id | input | NUM_CPU*4 | Per-processor acknowledged interrupt number |
| sgi_fire | output | 1 | Single-cycle request strobe, tells arbitration to re-evaluate |
| sgi_id | output | 10 | Decoded interrupt number |
| sgi_targets | output | NUM_CPU | Processors the request was sent to |
| sgi_pending | output | NUM_CPU*16 | Pending array, bit c*16+n for processor c, number n |

## Verification
The assertions assume that `wr_cpu` names an implemented processor whenever `wr_en` is high, and that the acknowledge inputs are zero while reset is held. The bench drives only requester indices 0 to NUM_CPU-1 and keeps every acknowledge input low except during its single acknowledge cycles. The sweep crosses every requester with every filter code and several explicit lists. The corner cases are:
- writes at the wrong offset;
- sub-word writes;
- out-of-range interrupt numbers;
- a set and an acknowledge of the same bit in the same cycle.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

   // target filter code, bits 25:24 of the trigger word
   typedef enum logic [1:0] {
      FLT_LIST   = 2'd0,
      FLT_OTHERS = 2'd1,
      FLT_SELF   = 2'd2,
      FLT_ALL    = 2'd3
   } sgi_filter_e;

   localparam int ID_W        = 10;
   localparam int ID_LSB      = 0;
   localparam int LIST_LSB    = 16;
   localparam int FILTER_LSB  = 24;
   localparam int MAX_CPU     = 8;
   localparam int NUM_SGI     = 16;
   localparam int SGI_W       = 4;

endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
   import sgi_pkg::*;
#(
   parameter int NUM_CPU = 4,
   localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic [31:0]         word,
   input  logic [CPU_W-1:0]    req_cpu,
   output logic [NUM_CPU-1:0]  mask,
   output logic [ID_W-1:0]     id
);

   localparam logic [NUM_CPU-1:0] ALL_MASK = {NUM_CPU{1'b1}};

   logic [NUM_CPU-1:0] self_oh;
   logic [NUM_CPU-1:0] list_m;
   sgi_filter_e        filt;

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_self
      assign self_oh[c] = (int'(req_cpu) == c);
   end

   if (NUM_CPU < MAX_CPU) begin : g_list_narrow
      logic unused_list_hi;
      assign unused_list_hi = ^word[LIST_LSB+MAX_CPU-1:LIST_LSB+NUM_CPU];
      assign list_m = word[LIST_LSB +: NUM_CPU];
   end else begin : g_list_full
      assign list_m = word[LIST_LSB +: MAX_CPU];
   end

   logic unused_bits;
   assign unused_bits = ^{word[31:26], word[15:10]};

   assign filt = sgi_filter_e'(word[FILTER_LSB +: 2]);
   assign id   = word[ID_LSB +: ID_W];

   always_comb begin
      unique case (filt)
         FLT_LIST:   mask = list_m & ALL_MASK;
         FLT_OTHERS: mask = ALL_MASK & ~self_oh;
         FLT_SELF:   mask = self_oh;
         default:    mask = ALL_MASK;
      endcase
   end

endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank
   import sgi_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_v,
   input  logic [SGI_W-1:0]   set_id,
   input  logic               ack_v,
   input  logic [SGI_W-1:0]   ack_id,
   output logic [NUM_SGI-1:0] pend
);

   for (genvar i = 0; i < NUM_SGI; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            pend[i] <= 1'b0;
         else if (set_v && set_id == SGI_W'(i))
            pend[i] <= 1'b1;
         else if (ack_v && ack_id == SGI_W'(i))
            pend[i] <= 1'b0;
      end
   end

   // R8
   set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_v |=> pend[$past(set_id)]);

   // R10
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_v && !(set_v && set_id == ack_id)) |=> !pend[$past(ack_id)]);

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_v && set_v && set_id == ack_id) |=> pend[$past(ack_id)]);

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
   import sgi_pkg::*;
#(
   parameter int          NUM_CPU   = 4,
   parameter int          ADDR_W    = 12,
   parameter logic [11:0] TRIG_OFFS = 12'hF00,
   localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic                      wr_word,
   input  logic [31:0]               wr_data,
   input  logic [CPU_W-1:0]          wr_cpu,
   input  logic [NUM_CPU-1:0]        ack_valid,
   input  logic [NUM_CPU*SGI_W-1:0]  ack_id,
   output logic                      sgi_fire,
   output logic [ID_W-1:0]           sgi_id,
   output logic [NUM_CPU-1:0]        sgi_targets,
   output logic [NUM_CPU*NUM_SGI-1:0] sgi_pending
);

   localparam logic [NUM_CPU-1:0] ALL_MASK = {NUM_CPU{1'b1}};

   if (NUM_CPU < 1 || NUM_CPU > MAX_CPU) begin : g_bad_cpu
      $error("sgi_dispatch: NUM_CPU must lie in 1..8");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("sgi_dispatch: ADDR_W must be at least 12");
   end

   logic                 hit;
   logic [NUM_CPU-1:0]   dec_mask;
   logic [ID_W-1:0]      dec_id;
   logic                 id_in_bank;

   assign hit        = wr_en && wr_word && (wr_addr == ADDR_W'(TRIG_OFFS));
   assign id_in_bank = (dec_id[ID_W-1:SGI_W] == '0);

   sgi_target_decode #(.NUM_CPU(NUM_CPU)) u_decode (
      .word    (wr_data),
      .req_cpu (wr_cpu),
      .mask    (dec_mask),
      .id      (dec_id)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sgi_fire    <= 1'b0;
         sgi_id      <= '0;
         sgi_targets <= '0;
      end else begin
         sgi_fire <= hit;
         if (hit) begin
            sgi_id      <= dec_id;
            sgi_targets <= dec_mask;
         end
      end
   end

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      sgi_pend_bank u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_v  (hit && dec_mask[c] && id_in_bank),
         .set_id (dec_id[SGI_W-1:0]),
         .ack_v  (ack_valid[c]),
         .ack_id (ack_id[c*SGI_W +: SGI_W]),
         .pend   (sgi_pending[c*NUM_SGI +: NUM_SGI])
      );
   end

   // R5 input assumption: the requester index names an implemented processor
   requester_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_cpu) < NUM_CPU));

   // R2
   no_write_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_word) |=> !sgi_fire);

   // R5
   others_excl_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wr_data[FILTER_LSB +: 2] == 2'd1) |=> !sgi_targets[$past(wr_cpu)]);

   // R6
   self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wr_data[FILTER_LSB +: 2] == 2'd2) |=> $onehot0(sgi_targets));

   // R7
   all_targets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wr_data[FILTER_LSB +: 2] == 2'd3) |=> sgi_targets == ALL_MASK);

   // R9
   high_id_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wr_data[ID_W-1:SGI_W] != '0 && ack_valid == '0) |=> $stable(sgi_pending));

endmodule

// File: tb/test_sgi_dispatch.sv
`timescale 1ns/1ps
module test_sgi_dispatch;

   localparam int NC = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [11:0]       wr_addr = '0;
   logic              wr_word = 1'b0;
   logic [31:0]       wr_data = '0;
   logic [1:0]        wr_cpu = '0;
   logic [NC-1:0]     ack_valid = '0;
   logic [NC*4-1:0]   ack_id = '0;
   logic              sgi_fire;
   logic [9:0]        sgi_id;
   logic [NC-1:0]     sgi_targets;
   logic [NC*16-1:0]  sgi_pending;

   int checks = 0;
   int failures = 0;
   logic [NC*16-1:0] exp_pend = '0;

   always #4 clk = ~clk;

   sgi_dispatch #(.NUM_CPU(NC)) i_sgi_dispatch (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_word, .wr_data, .wr_cpu,
      .ack_valid, .ack_id, .sgi_fire, .sgi_id, .sgi_targets, .sgi_pending
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NC-1:0] exp_mask(input int cpu, input int f, input logic [7:0] lst);
      logic [NC-1:0] all = '1;
      case (f)
         0: return lst[NC-1:0];
         1: return all & ~(NC'(1) << cpu);
         2: return NC'(1) << cpu;
         default: return all;
      endcase
   endfunction

   // one write; outputs checked at the negedge after the capturing edge
   task automatic do_write(input int cpu, input logic [11:0] addr, input bit full,
                           input int f, input logic [7:0] lst, input int id,
                           input bit expect_fire, input string req);
      logic [NC-1:0] m;
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = addr;
      wr_word = full;
      wr_cpu  = 2'(cpu);
      wr_data = {6'd0, 2'(f), lst, 6'd0, 10'(id)};
      @(negedge clk);
      wr_en = 1'b0;
      m = exp_mask(cpu, f, lst);
      if (expect_fire) begin
         check(sgi_fire == 1'b1, {req, " R3 fire"}, 64'(sgi_fire), 64'd1);
         check(sgi_id == 10'(id), {req, " R3 id"}, 64'(sgi_id), 64'(id));
         check(sgi_targets == m, req, 64'(sgi_targets), 64'(m));
         if (id < 16)
            for (int c = 0; c < NC; c++) if (m[c]) exp_pend[c*16+id] = 1'b1;
      end else begin
         check(sgi_fire == 1'b0, {req, " R2 no fire"}, 64'(sgi_fire), 64'd0);
      end
      check(sgi_pending == exp_pend, {req, " R8 pending"}, 64'(sgi_pending), 64'(exp_pend));
      @(negedge clk);
      check(sgi_fire == 1'b0, "R3 strobe one cycle", 64'(sgi_fire), 64'd0);
   endtask

   task automatic do_ack(input int cpu, input int id);
      @(negedge clk);
      ack_valid = NC'(1) << cpu;
      ack_id = '0;
      ack_id[cpu*4 +: 4] = 4'(id);
      @(negedge clk);
      ack_valid = '0;
      exp_pend[cpu*16+id] = 1'b0;
      check(sgi_pending == exp_pend, "R10 ack clears one bit", 64'(sgi_pending), 64'(exp_pend));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      check(sgi_fire == 1'b0, "R1 reset fire", 64'(sgi_fire), 64'd0);
      check(sgi_pending == '0, "R1 reset pending", 64'(sgi_pending), 64'd0);
      rst_n = 1'b1;

      // R4 R5 R6 R7 sweep
      for (int cpu = 0; cpu < NC; cpu++)
         for (int f = 0; f < 4; f++)
            for (int l = 0; l < 4; l++) begin
               logic [7:0] lst;
               string tag;
               lst = (l == 0) ? 8'h00 : (l == 1) ? 8'hFF : (l == 2) ? 8'hA5 : 8'h3C;
               tag = (f == 0) ? "R4 list" : (f == 1) ? "R5 others" : (f == 2) ? "R6 self" : "R7 all";
               do_write(cpu, 12'hF00, 1'b1, f, lst, (cpu*4 + f + l) % 16, 1'b1, tag);
            end

      // R10 clear everything
      for (int c = 0; c < NC; c++)
         for (int i = 0; i < 16; i++)
            if (exp_pend[c*16+i]) do_ack(c, i);
      check(sgi_pending == '0, "R10 all cleared", 64'(sgi_pending), 64'd0);

      // R2 ignored writes
      do_write(1, 12'hF04, 1'b1, 3, 8'h0F, 3, 1'b0, "R2 wrong offset");
      do_write(1, 12'hF00, 1'b0, 3, 8'h0F, 3, 1'b0, "R2 sub-word");
      do_write(1, 12'h000, 1'b1, 3, 8'h0F, 3, 1'b0, "R2 other register");

      // R9 out-of-range ids
      do_write(2, 12'hF00, 1'b1, 3, 8'h00, 16, 1'b1, "R9 id 16");
      do_write(0, 12'hF00, 1'b1, 0, 8'h0F, 1023, 1'b1, "R9 id 1023");

      // R11 set and ack same bit same cycle
      do_write(0, 12'hF00, 1'b1, 2, 8'h00, 5, 1'b1, "R6 setup");
      @(negedge clk);
      ack_valid = 4'b0001;
      ack_id = 16'h0005;
      wr_en = 1'b1; wr_addr = 12'hF00; wr_word = 1'b1; wr_cpu = 2'd0;
      wr_data = {6'd0, 2'd2, 8'd0, 6'd0, 10'd5};
      @(negedge clk);
      wr_en = 1'b0; ack_valid = '0;
      check(sgi_pending[5] == 1'b1, "R11 set wins", 64'(sgi_pending), 64'(exp_pend));
      do_ack(0, 5);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule